// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

The block is a memory-mapped doorbell unit that lets two processors signal each other over a simple peripheral register bus with one cycle of setup and one cycle of access. It has three channels. Each channel owns two 32-bit status words: one for incoming doorbells (receive) and one for outgoing doorbells (transmit). Software never writes a status word directly. It raises bits by writing a mask to a set word and drops bits by writing a mask to a clear word. A zero bit in either mask changes nothing.

The receive word of each channel drives that channel's interrupt, which stays high while any receive bit is set. The local handler reads the receive status, acts on it, and writes the same value to the receive clear word to acknowledge exactly those bits. To send, local software writes a mask to its transmit set word. It then polls the transmit status until it reads zero, which shows that the far end has consumed the message. The far-end processor appears as two strobe ports: one sets receive bits on a chosen channel, and the other clears transmit bits on a chosen channel. The bus is a register interface with no data stream, so it has no valid/ready handshake. Accesses complete with no wait states and never stall.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset every status word reads zero and all three interrupt outputs are low.
- R2: Channel banks start at byte offsets 0x000, 0x020 and 0x200. Each transmit bank sits 0x100 above its receive bank. Within a bank, status is at +0x0, set at +0x8 and clear at +0x10. Only these exact, word-aligned addresses are decoded.
- R3: A bus write to a set word ORs the written value into that bank's status word from the next clock edge on.
- R4: A bus write to a clear word drops the written 1 bits from that bank's status word. Writing back a value just read from status acknowledges exactly those bits.
- R5: When the same bit of one status word is both set and cleared in a cycle, it ends that cycle at 1.
- R6: Interrupt output bit c is high exactly while channel c's receive status is non-zero.
- R7: The far-end set strobe ORs its mask into the receive status of the selected channel. The far-end clear strobe drops its mask bits from the selected channel's transmit status. Both merge with a bus write in the same cycle. A channel index of 3 has no effect.
- R8: Reads of set words, clear words and unmapped offsets return zero. Writes to unmapped offsets and to status words change no status word.
- R9: Once the far end has cleared every transmit bit of a channel, that channel's transmit status reads zero, which is the sender's poll-complete condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| far_set_stb | input | 1 | Far end raises receive bits |
| far_set_ch | input | 2 | Channel for far_set_stb |
| far_set_mask | input | 32 | Bits to raise |
| far_clr_stb | input | 1 | Far end drops transmit bits |
| far_clr_ch | input | 2 | Channel for far_clr_stb |
| far_clr_mask | input | 32 | Bits to drop |
| irq | output | 3 | One interrupt per channel |

## Verification
The bench drives set and clear hits on the same bit in one cycle, from both directions. A design that gave clear priority would lose a doorbell that arrived during an acknowledge. It writes every bank with a distinct value and reads all six status words back. An address decode that used uniform channel spacing, or that put the transmit bank anywhere other than 0x100 above, would return the wrong word. It also probes unaligned addresses, gap addresses, writes to status words and the unused channel index 3, where a loose decode would corrupt state. Finally, it acknowledges by writing back the value just read and checks that the interrupt falls only when the last receive bit is gone.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_STAT = 2'd1,
    KIND_SET  = 2'd2,
    KIND_CLR  = 2'd3
  } reg_kind_e;

  localparam int unsigned OFS_STAT   = 0;
  localparam int unsigned OFS_SET    = 8;
  localparam int unsigned OFS_CLR    = 16;
  localparam int unsigned TX_DISTANCE = 256;
endpackage

// File: rtl/dbm_addr_decode.sv
module dbm_addr_decode
  import dbm_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 12,
  parameter logic [NCH*AW-1:0] BASES = {12'h200, 12'h020, 12'h000}
) (
  input  logic [AW-1:0]      addr,
  output logic [2*NCH-1:0]   bank_sel,
  output reg_kind_e          kind
);
  localparam int unsigned NBANK = 2 * NCH;

  always_comb begin
    bank_sel = '0;
    kind     = KIND_NONE;
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic [AW-1:0] b;
        b = BASES[c*AW +: AW] + ((s == 1) ? AW'(TX_DISTANCE) : AW'(0));
        if (addr == b + AW'(OFS_STAT)) begin
          bank_sel[2*c+s] = 1'b1;
          kind = KIND_STAT;
        end else if (addr == b + AW'(OFS_SET)) begin
          bank_sel[2*c+s] = 1'b1;
          kind = KIND_SET;
        end else if (addr == b + AW'(OFS_CLR)) begin
          bank_sel[2*c+s] = 1'b1;
          kind = KIND_CLR;
        end
      end
    end
  end

  // R2
  dec_onehot_chk: assert final ($onehot0(bank_sel) && ((bank_sel == '0) == (kind == KIND_NONE)) || $isunknown(addr));
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= (word_q & ~clr_mask) | set_mask;
  end

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((word_q & $past(set_mask)) == $past(set_mask)));

  // R5
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_mask & clr_mask)) |=> ((word_q & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));

  // R4
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_mask)) |=> ((word_q & $past(clr_mask & ~set_mask)) == '0));

  // R8
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(word_q));
endmodule

// File: rtl/dbm_rd_mux.sv
module dbm_rd_mux
  import dbm_pkg::*;
#(
  parameter int unsigned NBANK = 6,
  parameter int unsigned W     = 32
) (
  input  logic                rd_en,
  input  logic [NBANK-1:0]    bank_sel,
  input  reg_kind_e           kind,
  input  logic [NBANK*W-1:0]  words,
  output logic [W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en && kind == KIND_STAT) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_sel[b]) rdata = rdata | words[b*W +: W];
      end
    end
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import dbm_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 12,
  parameter int unsigned W   = 32,
  parameter logic [NCH*AW-1:0] BASES = {12'h200, 12'h020, 12'h000},
  localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH + 1) : 1,
  localparam int unsigned NBANK = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  output logic [W-1:0]  prdata,
  input  logic          far_set_stb,
  input  logic [CW-1:0] far_set_ch,
  input  logic [W-1:0]  far_set_mask,
  input  logic          far_clr_stb,
  input  logic [CW-1:0] far_clr_ch,
  input  logic [W-1:0]  far_clr_mask,
  output logic [NCH-1:0] irq
);
  logic [NBANK-1:0]   bank_sel;
  reg_kind_e          kind;
  logic               wr_en;
  logic               rd_en;
  logic [NBANK*W-1:0] words;
  logic [W-1:0]       set_v [NBANK];
  logic [W-1:0]       clr_v [NBANK];

  assign wr_en = psel & penable & pwrite;
  assign rd_en = psel & ~pwrite;

  dbm_addr_decode #(.NCH(NCH), .AW(AW), .BASES(BASES)) u_dec (
    .addr     (paddr),
    .bank_sel (bank_sel),
    .kind     (kind)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int unsigned B = 2 * c + s;
      logic [W-1:0] bus_set, bus_clr, far_set, far_clr;

      assign bus_set = (wr_en && bank_sel[B] && kind == KIND_SET) ? pwdata : '0;
      assign bus_clr = (wr_en && bank_sel[B] && kind == KIND_CLR) ? pwdata : '0;

      if (s == 0) begin : g_rx
        assign far_set = (far_set_stb && far_set_ch == CW'(c)) ? far_set_mask : '0;
        assign far_clr = '0;
      end else begin : g_tx
        assign far_set = '0;
        assign far_clr = (far_clr_stb && far_clr_ch == CW'(c)) ? far_clr_mask : '0;
      end

      assign set_v[B] = bus_set | far_set;
      assign clr_v[B] = bus_clr | far_clr;

      dbm_bank #(.W(W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_v[B]),
        .clr_mask (clr_v[B]),
        .word_q   (words[B*W +: W])
      );
    end

    assign irq[c] = |words[(2*c)*W +: W];

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(|set_v[2*c]));

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[c]) |-> $past(|clr_v[2*c]));
  end

  dbm_rd_mux #(.NBANK(NBANK), .W(W)) u_rd (
    .rd_en    (rd_en),
    .bank_sel (bank_sel),
    .kind     (kind),
    .words    (words),
    .rdata    (prdata)
  );

  // R8
  nonstat_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && kind != KIND_STAT) |-> (prdata == '0));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == KIND_NONE && !far_set_stb && !far_clr_stb) |=> $stable(words));
endmodule

// File: tb/test_doorbell_mailbox.sv
`timescale 1ns/1ps
module test_doorbell_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        far_set_stb = 1'b0, far_clr_stb = 1'b0;
  logic [1:0]  far_set_ch = '0, far_clr_ch = '0;
  logic [31:0] far_set_mask = '0, far_clr_mask = '0;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_rx [3];
  logic [31:0] m_tx [3];
  int          base [3] = '{0, 'h20, 'h200};

  always #2 clk = ~clk;

  doorbell_mailbox i_doorbell_mailbox (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .far_set_stb, .far_set_ch, .far_set_mask,
    .far_clr_stb, .far_clr_ch, .far_clr_mask, .irq
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 status, 2 set, 3 clear; bank = 2*channel + side (side 1 = transmit)
  function automatic void decode(input logic [11:0] a, output int bank, output int kind);
    bank = -1; kind = 0;
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 2; s++) begin
        int bb = base[c] + s * 'h100;
        if (a == 12'(bb))      begin bank = 2*c+s; kind = 1; end
        if (a == 12'(bb + 8))  begin bank = 2*c+s; kind = 2; end
        if (a == 12'(bb + 16)) begin bank = 2*c+s; kind = 3; end
      end
  endfunction

  function automatic logic [31:0] model_word(input int bank);
    return (bank % 2 == 0) ? m_rx[bank/2] : m_tx[bank/2];
  endfunction

  function automatic logic [11:0] addr_of(input int ch, input int side, input int kind);
    return 12'(base[ch] + side * 'h100 + ((kind == 1) ? 0 : (kind == 2) ? 8 : 16));
  endfunction

  task automatic bus_op(input string tag, input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit fs, input int fsc, input logic [31:0] fsm,
                        input bit fc, input int fcc, input logic [31:0] fcm,
                        output logic [31:0] rd);
    int bank, kind;
    logic [31:0] exp_rd;
    decode(a, bank, kind);
    exp_rd = (!wr && kind == 1) ? model_word(bank) : 32'h0;
    @(negedge clk);
    psel = 1; pwrite = wr; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    far_set_stb = fs; far_set_ch = 2'(fsc); far_set_mask = fsm;
    far_clr_stb = fc; far_clr_ch = 2'(fcc); far_clr_mask = fcm;
    #1 rd = prdata;
    if (!wr) check({tag, " read"}, rd, exp_rd);
    @(posedge clk); #1;
    for (int c = 0; c < 3; c++) begin
      logic [31:0] rs, rc, ts, tc;
      rs = (wr && kind == 2 && bank == 2*c)   ? d : 0;
      rc = (wr && kind == 3 && bank == 2*c)   ? d : 0;
      ts = (wr && kind == 2 && bank == 2*c+1) ? d : 0;
      tc = (wr && kind == 3 && bank == 2*c+1) ? d : 0;
      if (fs && fsc == c) rs |= fsm;
      if (fc && fcc == c) tc |= fcm;
      m_rx[c] = (m_rx[c] & ~rc) | rs;
      m_tx[c] = (m_tx[c] & ~tc) | ts;
    end
    psel = 0; penable = 0; pwrite = 0;
    far_set_stb = 0; far_clr_stb = 0;
    for (int c = 0; c < 3; c++) check("R6 irq", 32'(irq[c]), 32'(m_rx[c] != 0));
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus_op(tag, 1, a, d, 0, 0, 0, 0, 0, 0, x);
  endtask

  task automatic rd(input string tag, input logic [11:0] a, output logic [31:0] v);
    bus_op(tag, 0, a, 0, 0, 0, 0, 0, 0, 0, v);
  endtask

  task automatic read_all(input string tag);
    logic [31:0] v;
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 2; s++) rd(tag, addr_of(c, s, 1), v);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 3; c++) begin m_rx[c] = 0; m_tx[c] = 0; end
    void'($urandom(32'd20240611));
    #10 rst_n = 1;
    @(negedge clk);
    check("R1 irq", 32'(irq), 32'h0);
    read_all("R1");

    // R2: distinct values in every bank, read all six back
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 2; s++)
        wr("R2", addr_of(c, s, 2), 32'h11 << (4*(2*c+s)));
    read_all("R2");
    rd("R2 unaligned", 12'h001, v);
    check("R2 unaligned", v, 32'h0);
    for (int c = 0; c < 3; c++) begin
      wr("R4", addr_of(c, 0, 3), 32'hffff_ffff);
      wr("R4", addr_of(c, 1, 3), 32'hffff_ffff);
    end
    read_all("R4");

    // R3 accumulate
    wr("R3", 12'h028, 32'h1);
    wr("R3", 12'h028, 32'h4);
    rd("R3", 12'h020, v);
    check("R3 accumulate", v, 32'h5);

    // R4 acknowledge by write-back
    wr("R4", 12'h028, 32'h100);
    rd("R4", 12'h020, v);
    wr("R4", 12'h030, v);
    rd("R4", 12'h020, v);
    check("R4 ack", v, 32'h0);

    // R5 bus set vs far clear on tx ch0; bus clear vs far set on rx ch1
    bus_op("R5", 1, 12'h108, 32'h8, 0, 0, 0, 1, 0, 32'h8, v);
    rd("R5", 12'h100, v);
    check("R5 tx set wins", v, 32'h8);
    bus_op("R5", 1, 12'h030, 32'h2, 1, 1, 32'h2, 0, 0, 0, v);
    rd("R5", 12'h020, v);
    check("R5 rx set wins", v, 32'h2);

    // R7 merge on rx ch2, channel 3 ignored
    bus_op("R7", 1, 12'h208, 32'h10, 1, 2, 32'h20, 0, 0, 0, v);
    rd("R7", 12'h200, v);
    check("R7 merge", v, 32'h32 & 32'h30);
    bus_op("R7", 0, 12'h004, 0, 1, 3, 32'hffff_ffff, 1, 3, 32'hffff_ffff, v);
    read_all("R7 ch3");

    // R8 set/clear reads zero, unmapped and status writes ignored
    rd("R8 set rd", 12'h208, v);
    check("R8 set rd", v, 32'h0);
    rd("R8 clr rd", 12'h110, v);
    check("R8 clr rd", v, 32'h0);
    wr("R8", 12'h040, 32'hffff_ffff);
    wr("R8", 12'h00c, 32'hffff_ffff);
    wr("R8", 12'h200, 32'hffff_ffff);
    wr("R8", 12'h100, 32'h0);
    read_all("R8");

    // R9 poll: sender sets tx ch1, far end consumes
    wr("R9", 12'h128, 32'h0000_0a0a);
    rd("R9", 12'h120, v);
    check("R9 pending", 32'(v != 0), 32'h1);
    bus_op("R9", 0, 12'h120, 0, 0, 0, 0, 1, 1, 32'h0000_0a0a, v);
    rd("R9", 12'h120, v);
    check("R9 consumed", v, 32'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d, fm, cm;
      bit w, fs, fc;
      int fsc, fcc;
      if ($urandom_range(0, 7) == 0) a = 12'($urandom());
      else a = addr_of($urandom_range(0, 2), $urandom_range(0, 1), $urandom_range(1, 3));
      d  = $urandom() & $urandom();
      fm = $urandom() & $urandom() & $urandom();
      cm = $urandom() | $urandom();
      w  = $urandom_range(0, 1);
      fs = ($urandom_range(0, 3) == 0);
      fc = ($urandom_range(0, 3) == 0);
      fsc = $urandom_range(0, 3);
      fcc = $urandom_range(0, 3);
      bus_op("R7 random", w, a, d, fs, fsc, fm, fc, fcc, cm, v);
      if (i % 50 == 0) read_all("R3 random");
    end
    read_all("R4 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule